// File: doc/BRIEF.md
# Data Cache Line State and Lock Controller

This block holds the per-line state of a set-associative data cache: a valid, a dirty and a lock flag for every way of every set. It also holds one global round-robin pointer that chooses the way to replace. A maintenance command port acts on single lines or on the whole array. A fill port asks for a victim way in a given set. A probe port reads the state of any line, so a lookup path can qualify a hit. Tag comparison, data storage, the write-back transfer and address translation sit outside the block. The requester always supplies the set and way.

A lock is a reservation that only an unlock-all command can release. Invalidating a locked line, either one entry or the whole array, leaves its lock in place. A locked line that has been invalidated one entry at a time therefore stays out of service until the next unlock-all. Cleaning a dirty line raises a one-cycle write-back request that carries the set and way. The global invalidate walks the array one set per clock. While it runs, the block ignores commands and fills.

Top module: `line_state_ctl`

## Requirements
- R1: After reset every valid, dirty and lock flag is clear, `busy` and `wbNeeded` are low, and the replacement pointer rests on the last way. The first granted fill after reset therefore gets way 0.
- R2: The cache counts as enabled only when `ctrlWord[2]` and `mmuOn` are both 1. While it is disabled, `fillGrant` stays 0 and `probeValid` reads 0.
- R3: A fill is granted when `fillReq` is 1, the cache is enabled, `busy` is 0, `cmdValid` is 0 and the set has an unlocked way. The victim is the first unlocked way after the pointer, counting upward and wrapping from the last way to way 0. On a grant the pointer moves to the victim, and the line becomes valid and clean.
- R4: When every way of `fillSet` is locked, `fillNoVictim` is 1, no fill is granted and no state changes.
- R5: Invalidate-entry (cmdOp 1) clears the valid and dirty flags of the addressed line and leaves its lock flag unchanged.
- R6: Clean-entry (cmdOp 2) on a valid, dirty line raises `wbNeeded` for exactly the next cycle, with `wbSet` and `wbWay` naming that line. It clears the dirty flag and keeps the valid flag. On any other line it raises no request and changes nothing.
- R7: Invalidate-all (cmdOp 3) raises `busy` for exactly one cycle per set. In that time it clears the valid and dirty flags of every unlocked line. Locked lines keep their valid, dirty and lock flags.
- R8: While `busy` is 1, commands are ignored and fills are not granted.
- R9: Unlock-all (cmdOp 5) clears every lock flag. After that, an invalidate-all removes those lines.
- R10: Lock-line (cmdOp 4) sets the lock flag of the addressed line. Mark-dirty (cmdOp 6) sets the dirty flag only if the line is valid and the cache is enabled. cmdOp 0 does nothing.
- R11: In a cycle where `cmdValid` is 1, a fill request is not granted, whatever cmdOp is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | CTRL_W | Control word; bit EN_BIT (2) enables the cache |
| mmuOn | input | 1 | Translation enabled; required for the cache to be enabled |
| cmdValid | input | 1 | Maintenance command present |
| cmdOp | input | 3 | Command code: 0 none, 1 invalidate entry, 2 clean entry, 3 invalidate all, 4 lock line, 5 unlock all, 6 mark dirty |
| cmdSet | input | log2(SETS) | Set addressed by the command |
| cmdWay | input | log2(WAYS) | Way addressed by the command |
| busy | output | 1 | Invalidate-all sweep in progress |
| fillReq | input | 1 | Allocation request |
| fillSet | input | log2(SETS) | Set to allocate into |
| fillWay | output | log2(WAYS) | Chosen victim way |
| fillNoVictim | output | 1 | Every way of fillSet is locked |
| fillGrant | output | 1 | Allocation taken this cycle |
| wbNeeded | output | 1 | One-cycle write-back request |
| wbSet | output | log2(SETS) | Set of the line to write back |
| wbWay | output | log2(WAYS) | Way of the line to write back |
| probeSet | input | log2(SETS) | Set to read |
| probeWay | input | log2(WAYS) | Way to read |
| probeValid | output | 1 | Line valid and cache enabled |
| probeDirty | output | 1 | Line dirty flag |
| probeLocked | output | 1 | Line lock flag |

## Verification
The bench builds the block with 4 sets and 8 ways. At that size, locking every way of one set to reach the no-victim case takes only eight commands. The replacement pointer also wraps past the last way several times within a few dozen fills. The invalidate-all sweep lasts four cycles, so the bench issues commands and fills during it and then probes all 32 lines afterwards.

// File: rtl/line_state_pkg.sv
package line_state_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_INV_ENTRY  = 3'd1,
    OP_CLEAN      = 3'd2,
    OP_INV_ALL    = 3'd3,
    OP_LOCK       = 3'd4,
    OP_UNLOCK_ALL = 3'd5,
    OP_MARK_DIRTY = 3'd6
  } cmdOpE;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic invEntry;
    logic cleanEntry;
    logic lockEntry;
    logic markDirty;
    logic unlockAll;
    logic sweepStep;
    logic allocGo;
  } strobeT;

endpackage

// File: rtl/line_state_ctrl.sv
module line_state_ctrl
  import line_state_pkg::*;
#(
  parameter int SETS = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [2:0]               cmdOp,
  input  logic                     fillReq,
  input  logic                     cacheOn,
  output strobeT                   strb,
  output logic                     busy,
  output logic [$clog2(SETS)-1:0]  sweepSet
);
  localparam int SET_W = $clog2(SETS);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

  logic             busyQ;
  logic [SET_W-1:0] sweepIdxQ;
  logic             accept;

  assign accept   = cmdValid && !busyQ;
  assign busy     = busyQ;
  assign sweepSet = sweepIdxQ;

  always_comb begin
    strb = '0;
    if (accept) begin
      unique case (cmdOp)
        OP_INV_ENTRY:  strb.invEntry   = 1'b1;
        OP_CLEAN:      strb.cleanEntry = 1'b1;
        OP_LOCK:       strb.lockEntry  = 1'b1;
        OP_UNLOCK_ALL: strb.unlockAll  = 1'b1;
        OP_MARK_DIRTY: strb.markDirty  = cacheOn;
        default:       ;
      endcase
    end
    strb.sweepStep = busyQ;
    strb.allocGo   = fillReq && cacheOn && !busyQ && !cmdValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      sweepIdxQ <= '0;
    end else if (accept && cmdOp == OP_INV_ALL) begin
      busyQ     <= 1'b1;
      sweepIdxQ <= '0;
    end else if (busyQ) begin
      if (sweepIdxQ == LAST_SET) busyQ <= 1'b0;
      sweepIdxQ <= sweepIdxQ + 1'b1;
    end
  end

  // R7
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> sweepIdxQ == '0);
  // R7
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(sweepIdxQ) == LAST_SET);
  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !(strb.allocGo || strb.invEntry || strb.cleanEntry ||
                strb.lockEntry || strb.unlockAll || strb.markDirty));

endmodule

// File: rtl/line_state_dp.sv
module line_state_dp
  import line_state_pkg::*;
#(
  parameter int SETS = 32,
  parameter int WAYS = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strb,
  input  logic                     cacheOn,
  input  logic [$clog2(SETS)-1:0]  cmdSet,
  input  logic [$clog2(WAYS)-1:0]  cmdWay,
  input  logic [$clog2(SETS)-1:0]  sweepSet,
  input  logic [$clog2(SETS)-1:0]  fillSet,
  output logic [$clog2(WAYS)-1:0]  fillWay,
  output logic                     fillNoVictim,
  output logic                     fillGrant,
  output logic                     wbNeeded,
  output logic [$clog2(SETS)-1:0]  wbSet,
  output logic [$clog2(WAYS)-1:0]  wbWay,
  input  logic [$clog2(SETS)-1:0]  probeSet,
  input  logic [$clog2(WAYS)-1:0]  probeWay,
  output logic                     probeValid,
  output logic                     probeDirty,
  output logic                     probeLocked
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  validQ [SETS];
  logic [WAYS-1:0]  dirtyQ [SETS];
  logic [WAYS-1:0]  lockQ  [SETS];
  logic [WAY_W-1:0] ptrQ;

  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] cand;
  logic             found;

  // first unlocked way above the pointer, wrapping; pointer itself is last
  always_comb begin
    victim = ptrQ;
    found  = 1'b0;
    cand   = ptrQ;
    for (int k = 1; k <= WAYS; k++) begin
      cand = ptrQ + WAY_W'(k);
      if (!found && !lockQ[fillSet][cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
  end

  assign fillWay      = victim;
  assign fillNoVictim = !found;
  assign fillGrant    = strb.allocGo && found;

  assign probeValid  = validQ[probeSet][probeWay] && cacheOn;
  assign probeDirty  = dirtyQ[probeSet][probeWay];
  assign probeLocked = lockQ[probeSet][probeWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
        lockQ[s]  <= '0;
      end
      ptrQ     <= WAY_W'(WAYS - 1);
      wbNeeded <= 1'b0;
      wbSet    <= '0;
      wbWay    <= '0;
    end else begin
      wbNeeded <= strb.cleanEntry && validQ[cmdSet][cmdWay] && dirtyQ[cmdSet][cmdWay];
      wbSet    <= cmdSet;
      wbWay    <= cmdWay;
      if (fillGrant) begin
        validQ[fillSet][victim] <= 1'b1;
        dirtyQ[fillSet][victim] <= 1'b0;
        ptrQ                    <= victim;
      end
      if (strb.invEntry) begin
        validQ[cmdSet][cmdWay] <= 1'b0;
        dirtyQ[cmdSet][cmdWay] <= 1'b0;
      end
      if (strb.cleanEntry) dirtyQ[cmdSet][cmdWay] <= 1'b0;
      if (strb.lockEntry)  lockQ[cmdSet][cmdWay]  <= 1'b1;
      if (strb.markDirty && validQ[cmdSet][cmdWay]) dirtyQ[cmdSet][cmdWay] <= 1'b1;
      if (strb.unlockAll) begin
        for (int s = 0; s < SETS; s++) lockQ[s] <= '0;
      end
      if (strb.sweepStep) begin
        validQ[sweepSet] <= validQ[sweepSet] & lockQ[sweepSet];
        dirtyQ[sweepSet] <= dirtyQ[sweepSet] & lockQ[sweepSet];
      end
    end
  end

  // R3
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillGrant |-> !lockQ[fillSet][fillWay]);
  // R3
  ptr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillGrant |=> ptrQ == $past(fillWay));
  // R6
  wb_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbNeeded |-> $past(strb.cleanEntry));
  // R5
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.invEntry && lockQ[cmdSet][cmdWay] |=> lockQ[$past(cmdSet)][$past(cmdWay)]);

endmodule

// File: rtl/line_state_ctl.sv
module line_state_ctl
  import line_state_pkg::*;
#(
  parameter int SETS   = 32,
  parameter int WAYS   = 32,
  parameter int CTRL_W = 8,
  parameter int EN_BIT = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CTRL_W-1:0]        ctrlWord,
  input  logic                     mmuOn,
  input  logic                     cmdValid,
  input  logic [2:0]               cmdOp,
  input  logic [$clog2(SETS)-1:0]  cmdSet,
  input  logic [$clog2(WAYS)-1:0]  cmdWay,
  output logic                     busy,
  input  logic                     fillReq,
  input  logic [$clog2(SETS)-1:0]  fillSet,
  output logic [$clog2(WAYS)-1:0]  fillWay,
  output logic                     fillNoVictim,
  output logic                     fillGrant,
  output logic                     wbNeeded,
  output logic [$clog2(SETS)-1:0]  wbSet,
  output logic [$clog2(WAYS)-1:0]  wbWay,
  input  logic [$clog2(SETS)-1:0]  probeSet,
  input  logic [$clog2(WAYS)-1:0]  probeWay,
  output logic                     probeValid,
  output logic                     probeDirty,
  output logic                     probeLocked
);
  localparam int SET_W = $clog2(SETS);

  logic             cacheOn;
  strobeT           strb;
  logic [SET_W-1:0] sweepSet;

  assign cacheOn = ctrlWord[EN_BIT] && mmuOn;

  line_state_ctrl #(.SETS(SETS)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .fillReq(fillReq), .cacheOn(cacheOn), .strb(strb), .busy(busy),
    .sweepSet(sweepSet)
  );

  line_state_dp #(.SETS(SETS), .WAYS(WAYS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cacheOn(cacheOn),
    .cmdSet(cmdSet), .cmdWay(cmdWay), .sweepSet(sweepSet),
    .fillSet(fillSet), .fillWay(fillWay), .fillNoVictim(fillNoVictim),
    .fillGrant(fillGrant), .wbNeeded(wbNeeded), .wbSet(wbSet), .wbWay(wbWay),
    .probeSet(probeSet), .probeWay(probeWay), .probeValid(probeValid),
    .probeDirty(probeDirty), .probeLocked(probeLocked)
  );

endmodule

// File: tb/test_line_state_ctl.sv
`timescale 1ns/100ps
module test_line_state_ctl;
  localparam int S = 4;
  localparam int W = 8;
  localparam int SW = 2;
  localparam int WW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic [7:0] ctrlWord = '0;
  logic mmuOn = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [SW-1:0] cmdSet = '0, fillSet = '0, probeSet = '0, wbSet;
  logic [WW-1:0] cmdWay = '0, probeWay = '0, fillWay, wbWay;
  logic fillReq = 1'b0;
  logic busy, fillNoVictim, fillGrant, wbNeeded, probeValid, probeDirty, probeLocked;

  line_state_ctl #(.SETS(S), .WAYS(W)) i_line_state_ctl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .mmuOn(mmuOn),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSet(cmdSet), .cmdWay(cmdWay),
    .busy(busy), .fillReq(fillReq), .fillSet(fillSet), .fillWay(fillWay),
    .fillNoVictim(fillNoVictim), .fillGrant(fillGrant), .wbNeeded(wbNeeded),
    .wbSet(wbSet), .wbWay(wbWay), .probeSet(probeSet), .probeWay(probeWay),
    .probeValid(probeValid), .probeDirty(probeDirty), .probeLocked(probeLocked)
  );

  // behavioural reference state
  bit mV [S][W];
  bit mD [S][W];
  bit mL [S][W];
  int mPtr = W - 1;
  bit mBusy = 0;
  int mIdx = 0;
  bit mWb = 0;
  int mWbSet = 0, mWbWay = 0;
  int probeCnt = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic step(string tag, bit cv, int op, int cs, int cw, bit fr, int fs);
    bit on, found, accept, grant;
    int vic;
    cmdValid = cv; cmdOp = 3'(op); cmdSet = SW'(cs); cmdWay = WW'(cw);
    fillReq = fr; fillSet = SW'(fs);
    probeSet = SW'((probeCnt / W) % S); probeWay = WW'(probeCnt % W);
    probeCnt++;
    #1;
    on = ctrlWord[2] && mmuOn;
    found = 0; vic = mPtr;
    for (int k = 1; k <= W; k++) begin
      int c = (mPtr + k) % W;
      if (!found && !mL[fs][c]) begin found = 1; vic = c; end
    end
    accept = cv && !mBusy;
    grant = fr && on && !mBusy && !cv && found;
    chk(tag, "busy", int'(busy), int'(mBusy));
    chk(tag, "wbNeeded", int'(wbNeeded), int'(mWb));
    if (mWb) begin
      chk(tag, "wbSet", int'(wbSet), mWbSet);
      chk(tag, "wbWay", int'(wbWay), mWbWay);
    end
    chk(tag, "fillNoVictim", int'(fillNoVictim), int'(!found));
    if (fr && found) chk(tag, "fillWay", int'(fillWay), vic);
    chk(tag, "fillGrant", int'(fillGrant), int'(grant));
    chk(tag, "probeValid", int'(probeValid), int'(mV[probeSet][probeWay] && on));
    chk(tag, "probeDirty", int'(probeDirty), int'(mD[probeSet][probeWay]));
    chk(tag, "probeLocked", int'(probeLocked), int'(mL[probeSet][probeWay]));
    // next state
    mWb = accept && op == 2 && mV[cs][cw] && mD[cs][cw];
    mWbSet = cs; mWbWay = cw;
    if (grant) begin mV[fs][vic] = 1; mD[fs][vic] = 0; mPtr = vic; end
    if (mBusy) begin
      for (int w = 0; w < W; w++)
        if (!mL[mIdx][w]) begin mV[mIdx][w] = 0; mD[mIdx][w] = 0; end
      if (mIdx == S - 1) mBusy = 0;
      mIdx = (mIdx + 1) % S;
    end
    if (accept) begin
      case (op)
        1: begin mV[cs][cw] = 0; mD[cs][cw] = 0; end
        2: mD[cs][cw] = 0;
        3: begin mBusy = 1; mIdx = 0; end
        4: mL[cs][cw] = 1;
        5: for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) mL[s][w] = 0;
        6: if (on && mV[cs][cw]) mD[cs][cw] = 1;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: disabled by control bit, then by translation input
    ctrlWord = 8'h00; mmuOn = 1'b1;
    step("R2", 0, 0, 0, 0, 1, 0);
    ctrlWord = 8'h04; mmuOn = 1'b0;
    step("R2", 0, 0, 0, 0, 1, 1);
    ctrlWord = 8'hFB; mmuOn = 1'b1;
    step("R2", 0, 0, 0, 0, 1, 2);
    // R1: all lines clear after reset, first victim is way 0
    ctrlWord = 8'h04; mmuOn = 1'b1;
    probeCnt = 0;
    idle("R1", S * W);
    step("R1", 0, 0, 0, 0, 1, 0);
    // R3: fills rotate through ways and wrap
    for (int i = 0; i < 12; i++) step("R3", 0, 0, 0, 0, 1, i % S);
    // R10: mark dirty, valid and invalid lines, enabled and disabled
    step("R10", 1, 6, 0, 0, 0, 0);
    step("R10", 1, 6, 3, 7, 0, 0);
    step("R10", 1, 6, 1, 1, 0, 0);
    ctrlWord = 8'h00;
    step("R10", 1, 6, 2, 2, 0, 0);
    ctrlWord = 8'h04;
    step("R10", 1, 0, 0, 3, 0, 0);
    // R6: clean dirty line, clean again, clean an invalid line
    step("R6", 1, 2, 0, 0, 0, 0);
    step("R6", 1, 2, 0, 0, 0, 0);
    step("R6", 1, 2, 3, 7, 0, 0);
    step("R6", 1, 2, 1, 1, 0, 0);
    idle("R6", 2);
    // R4: lock every way of set 2
    for (int w = 0; w < W; w++) step("R10", 1, 4, 2, w, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 2);
    step("R4", 0, 0, 0, 0, 1, 2);
    // R3: locked ways in set 1 are skipped
    step("R10", 1, 4, 1, 4, 0, 0);
    step("R10", 1, 4, 1, 5, 0, 0);
    for (int i = 0; i < 10; i++) step("R3", 0, 0, 0, 0, 1, 1);
    // R11: command present blocks fill
    step("R11", 1, 0, 0, 0, 1, 0);
    step("R11", 1, 6, 1, 4, 1, 3);
    // R5: invalidate locked and unlocked entries
    step("R5", 1, 1, 2, 0, 0, 0);
    step("R5", 1, 1, 1, 4, 0, 0);
    step("R5", 1, 1, 0, 1, 0, 0);
    step("R10", 1, 6, 2, 1, 0, 0);
    step("R10", 1, 6, 3, 0, 0, 0);
    // R7/R8: sweep, with traffic ignored meanwhile
    step("R7", 1, 3, 0, 0, 0, 0);
    step("R8", 1, 4, 0, 7, 1, 0);
    step("R8", 1, 5, 0, 0, 1, 3);
    step("R8", 1, 1, 2, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0);
    probeCnt = 0;
    idle("R7", S * W);
    // R9: unlock all, then sweep removes former locked lines
    step("R9", 1, 5, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 2);
    step("R9", 1, 3, 0, 0, 0, 0);
    probeCnt = 0;
    idle("R9", S * W + 2);
    finished = 1;
    summary();
    $finish;
  end

endmodule